// File: doc/BRIEF.md
# Receive Queue Screener (Port and DS/TC Rules)

This block watches the bytes of each received Ethernet frame and picks a receive queue for it. It holds a bank of screening rules. Each rule carries a target queue, an optional match on the IPv4 DS/TC byte, an optional match on the UDP destination port, and a drop flag. Frame bytes arrive one per accepted cycle, tagged with a start marker on the first byte and a last marker on the final byte. The block keeps only the three header bytes it needs. It gives exactly one verdict per frame: a match flag, a 4-bit queue number and a drop request.

A rule qualifies when at least one of its enabled criteria agrees with the frame and none of its enabled criteria disagrees. The lowest-numbered qualifying rule supplies the verdict. A frame that no rule claims goes to queue 0. The verdict appears one cycle after the header's last needed byte (offset 37). If the frame ends before that byte, it appears one cycle after the frame's last byte instead. Rules are loaded through a simple write port, one whole rule word per write.

Top module: `rx_queue_screen`

## Requirements
- R1: A rule word is laid out as queue [3:0], DS/TC value [11:4], UDP port value [27:12], DS/TC enable bit 28, port enable bit 29, drop bit 30. Bit 31 is ignored.
- R2: The compared UDP port is big-endian. Frame byte 36 is the high byte and byte 37 is the low byte. Offset 0 is the byte carrying the start marker.
- R3: The compared DS/TC value is the frame byte at offset 15.
- R4: A rule qualifies only if one or more of its enabled criteria match and none of its enabled criteria mismatch. A rule with both enables clear never qualifies.
- R5: When several rules qualify, the one with the lowest index decides the verdict.
- R6: When no rule qualifies, the verdict has the match flag low, queue 0 and drop low.
- R7: When the deciding rule has its drop bit set, the verdict has the match flag high, drop high and queue 0.
- R8: res_valid pulses for one cycle, exactly once per frame. The pulse comes in the cycle after the byte at offset 37 is accepted, or after the last-marked byte if that comes first. Cycles with rx_valid low are ignored. Bytes seen after a frame ends and before the next start marker are ignored. When res_valid is low, the other result outputs are 0.
- R9: In a frame too short to contain a criterion's bytes, that criterion counts as a mismatch.
- R10: A write stores cfg_data into rule cfg_idx. The new rule applies to verdicts triggered by bytes accepted after the write cycle. A write whose index is NUM_RULES or more changes nothing.
- R11: After reset, every rule is cleared and res_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Rule write strobe |
| cfg_idx | input | IDX_W | Index of the rule being written |
| cfg_data | input | 32 | Rule word to store |
| rx_valid | input | 1 | Byte present this cycle |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Marks the last byte of a frame |
| rx_byte | input | 8 | Frame byte |
| res_valid | output | 1 | Verdict strobe, one cycle per frame |
| res_hit | output | 1 | A rule claimed the frame |
| res_queue | output | 4 | Selected queue |
| res_drop | output | 1 | The claiming rule asks for a drop |

## Verification
The bench builds the block with NUM_RULES = 6, so the index port is 3 bits wide. That leaves indices 6 and 7 unused, which lets the bench check that out-of-range writes are ignored, and the checks watch the verdict for any effect. Six rules also allow several matching rules to sit at scattered indices, which exercises the priority order. Random frame lengths from 1 to 64 bytes cover both trigger points (the header byte and the early last marker) and both truncation thresholds. Idle gaps placed between bytes test that cycles with rx_valid low are skipped.

// File: rtl/scr_pkg.sv
// Shared types and constants for the receive queue screener.
// Assumes frames start at the Ethernet destination address with no VLAN tag.
package scr_pkg;

    localparam int QUEUE_W     = 4;
    localparam int DS_OFF      = 15;
    localparam int PORT_HI_OFF = 36;
    localparam int PORT_LO_OFF = 37;
    localparam int CNT_W       = 6;
    localparam int RULE_W      = 31;

    // One screening rule; the bit order matches the write word [30:0].
    typedef struct packed {
        logic        drop;
        logic        port_en;
        logic        ds_en;
        logic [15:0] port;
        logic [7:0]  ds;
        logic [QUEUE_W-1:0] queue;
    } scr_rule_t;

    // Header fields seen so far in the current frame.
    typedef struct packed {
        logic        ds_ok;
        logic [7:0]  ds;
        logic        port_ok;
        logic [15:0] port;
    } scr_hdr_t;

endpackage

// File: rtl/scr_hdr_capture.sv
// Tracks the byte offset within the current frame and keeps the DS/TC byte
// and the UDP port bytes. hdr_o includes the byte being accepted this cycle,
// so fire_o and hdr_o together describe the frame as of this cycle's edge.
// Assumes offsets are contiguous: a frame's bytes arrive in order with no holes.
// Bytes before the first start marker, or after a frame's trigger, are ignored.
module scr_hdr_capture
    import scr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic [7:0] in_byte,
    output scr_hdr_t   hdr_o,
    output logic       fire_o
);
    localparam logic [CNT_W-1:0] SAT_OFF = CNT_W'(PORT_LO_OFF + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cur_off;
    logic             done_q;
    logic             live_done;
    scr_hdr_t         hdr_q;

    // Offset of the present byte, and the header view including this byte.
    always_comb begin
        cur_off   = in_sof ? '0 : cnt_q;
        live_done = (in_valid && in_sof) ? 1'b0 : done_q;
        hdr_o     = hdr_q;
        if (in_valid && in_sof) begin
            hdr_o.ds_ok   = 1'b0;
            hdr_o.port_ok = 1'b0;
        end
        if (in_valid) begin
            if (cur_off == CNT_W'(DS_OFF)) begin
                hdr_o.ds    = in_byte;
                hdr_o.ds_ok = 1'b1;
            end
            if (cur_off == CNT_W'(PORT_HI_OFF)) begin
                hdr_o.port[15:8] = in_byte;
            end
            if (cur_off == CNT_W'(PORT_LO_OFF)) begin
                hdr_o.port[7:0] = in_byte;
                hdr_o.port_ok   = 1'b1;
            end
        end
        fire_o = in_valid && !live_done &&
                 (in_eof || cur_off == CNT_W'(PORT_LO_OFF));
    end

    // Advance the saturating offset counter and keep the captured header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b1;
            hdr_q  <= '0;
        end else if (in_valid) begin
            cnt_q  <= (cur_off >= SAT_OFF) ? SAT_OFF : cur_off + 1'b1;
            done_q <= live_done || fire_o;
            hdr_q  <= hdr_o;
        end
    end

    // Once a verdict has been triggered, the frame stays closed until a new start.
    assert_closed_after_fire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> done_q);

    // Reaching offset 37 in an open frame always triggers the verdict.
    assert_fire_at_port_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sof && !done_q && cnt_q == CNT_W'(PORT_LO_OFF)) |-> fire_o);

    // The port can only be complete if the DS/TC byte was seen earlier.
    assert_port_after_ds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_q.port_ok |-> hdr_q.ds_ok);

endmodule

// File: rtl/scr_rule_bank.sv
// Storage for the screening rules, loaded one whole word per write.
// Assumes cfg_idx values of NUM_RULES or more are unused; writes to them are dropped.
module scr_rule_bank
    import scr_pkg::*;
#(
    parameter int NUM_RULES = 4,
    parameter int IDX_W     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDX_W-1:0]          idx,
    input  logic [31:0]               data,
    output scr_rule_t [NUM_RULES-1:0] rules_o
);
    logic unused_top_bit;
    assign unused_top_bit = data[31];

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_slot
        // Hold one rule; load it when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rules_o[g] <= '0;
            end else if (we && idx == IDX_W'(g)) begin
                rules_o[g] <= scr_rule_t'(data[RULE_W-1:0]);
            end
        end

        assert_write_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (we && idx == IDX_W'(g)) |=> rules_o[g] == scr_rule_t'($past(data[RULE_W-1:0])));

        assert_slot_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && idx == IDX_W'(g)) |=> $stable(rules_o[g]));
    end

endmodule

// File: rtl/scr_rule_match.sv
// Judges one rule against the header view: an enabled criterion that is absent
// or unequal counts as a mismatch, and a qualifying rule needs at least one hit.
module scr_rule_match
    import scr_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  scr_rule_t rule_i,
    input  scr_hdr_t  hdr_i,
    output logic      qual_o
);
    logic ds_eq;
    logic port_eq;
    logic any_hit;
    logic any_miss;

    // Combine the two criteria under the all-enabled-must-agree rule.
    always_comb begin
        ds_eq    = hdr_i.ds_ok   && (hdr_i.ds   == rule_i.ds);
        port_eq  = hdr_i.port_ok && (hdr_i.port == rule_i.port);
        any_hit  = (rule_i.ds_en && ds_eq) || (rule_i.port_en && port_eq);
        any_miss = (rule_i.ds_en && !ds_eq) || (rule_i.port_en && !port_eq);
        qual_o   = any_hit && !any_miss;
    end

    assert_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!rule_i.ds_en && !rule_i.port_en) |-> !qual_o);

    assert_short_port_misses_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rule_i.port_en && !hdr_i.port_ok) |-> !qual_o);

    assert_short_ds_misses_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rule_i.ds_en && !hdr_i.ds_ok) |-> !qual_o);

endmodule

// File: rtl/scr_prio_pick.sv
// Grants the lowest-indexed asserted request; any_o reports that one exists.
module scr_prio_pick #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    // Scan upward and keep only the first request found.
    always_comb begin
        grant_o = '0;
        any_o   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !any_o) begin
                grant_o[i] = 1'b1;
                any_o      = 1'b1;
            end
        end
    end

    assert_single_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    assert_grant_requested_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~req_i) == '0);

    assert_grant_when_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i != '0) |-> (grant_o != '0));

endmodule

// File: rtl/rx_queue_screen.sv
// Receive queue screener top. It captures the header bytes, judges every rule
// in parallel, picks the lowest qualifying index, and registers one verdict
// per frame. Assumes the byte stream brackets each frame with start/last markers.
module rx_queue_screen
    import scr_pkg::*;
#(
    parameter int NUM_RULES = 4,
    parameter int IDX_W     = (NUM_RULES > 1) ? $clog2(NUM_RULES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [31:0]      cfg_data,
    input  logic             rx_valid,
    input  logic             rx_sof,
    input  logic             rx_eof,
    input  logic [7:0]       rx_byte,
    output logic             res_valid,
    output logic             res_hit,
    output logic [3:0]       res_queue,
    output logic             res_drop
);
    scr_rule_t [NUM_RULES-1:0] rules;
    scr_hdr_t                  hdr;
    logic                      fire;
    logic [NUM_RULES-1:0]      qual;
    logic [NUM_RULES-1:0]      grant;
    logic                      any;
    scr_rule_t                 win;

    scr_hdr_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (rx_valid),
        .in_sof   (rx_sof),
        .in_eof   (rx_eof),
        .in_byte  (rx_byte),
        .hdr_o    (hdr),
        .fire_o   (fire)
    );

    scr_rule_bank #(.NUM_RULES(NUM_RULES), .IDX_W(IDX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .idx     (cfg_idx),
        .data    (cfg_data),
        .rules_o (rules)
    );

    for (genvar g = 0; g < NUM_RULES; g++) begin : g_match
        scr_rule_match u_match (
            .clk    (clk),
            .rst_n  (rst_n),
            .rule_i (rules[g]),
            .hdr_i  (hdr),
            .qual_o (qual[g])
        );
    end

    scr_prio_pick #(.N(NUM_RULES)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (qual),
        .grant_o (grant),
        .any_o   (any)
    );

    // Select the granted rule's fields with a one-hot OR mux.
    always_comb begin
        win = '0;
        for (int i = 0; i < NUM_RULES; i++) begin
            if (grant[i]) begin
                win = win | rules[i];
            end
        end
    end

    // Register the verdict on the trigger edge; outputs idle at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_queue <= '0;
            res_drop  <= 1'b0;
        end else begin
            res_valid <= fire;
            res_hit   <= fire && any;
            res_drop  <= fire && any && win.drop;
            res_queue <= (fire && any && !win.drop) ? win.queue : '0;
        end
    end

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && !res_drop && res_queue == '0));

    assert_drop_no_queue_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_drop |-> (res_hit && res_queue == '0));

    assert_miss_queue_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_queue == '0 && !res_drop));

    assert_single_byte_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sof && rx_eof) |=> res_valid);

endmodule

// File: tb/tb_rx_queue_screen.sv
`timescale 1ns/1ps
module tb_rx_queue_screen;
    localparam int NR = 6;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [IW-1:0] cfg_idx;
    logic [31:0]   cfg_data;
    logic          rx_valid, rx_sof, rx_eof;
    logic [7:0]    rx_byte;
    logic          res_valid, res_hit, res_drop;
    logic [3:0]    res_queue;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 0;

    logic [30:0] m_rule [NR];
    logic [7:0]  fb [64];

    always #2 clk = ~clk;

    rx_queue_screen #(.NUM_RULES(NR)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_byte(rx_byte), .res_valid(res_valid),
        .res_hit(res_hit), .res_queue(res_queue), .res_drop(res_drop)
    );

    // Expected verdict {hit, drop, queue} for fb[0:len-1] under the rule model.
    function automatic logic [5:0] expect_verdict(input int len);
        for (int i = 0; i < NR; i++) begin
            logic [30:0] r;
            bit hit, miss;
            r = m_rule[i];
            hit = 0; miss = 0;
            if (r[28]) begin
                if (len > 15 && fb[15] == r[11:4]) hit = 1; else miss = 1;
            end
            if (r[29]) begin
                if (len > 37 && {fb[36], fb[37]} == r[27:12]) hit = 1; else miss = 1;
            end
            if (hit && !miss) return r[30] ? 6'b110000 : {2'b10, r[3:0]};
        end
        return 6'b0;
    endfunction

    function automatic logic [31:0] mk_rule(input bit drop, input bit pe, input bit de,
                                            input logic [15:0] port, input logic [7:0] ds,
                                            input logic [3:0] q);
        return {1'b0, drop, pe, de, port, ds, q};
    endfunction

    task automatic check_quiet(input string tag);
        n_chk++;
        if (res_valid !== 1'b0 || res_hit !== 1'b0 || res_drop !== 1'b0 || res_queue !== 4'd0) begin
            n_fail++;
            $display("FAIL %s: idle outputs v=%b h=%b d=%b q=%0d, expected all zero",
                     tag, res_valid, res_hit, res_drop, res_queue);
        end
    endtask

    task automatic check_verdict(input logic [5:0] e, input string tag);
        n_chk++;
        if (res_valid !== 1'b1 || {res_hit, res_drop, res_queue} !== e) begin
            n_fail++;
            $display("FAIL %s: v=%b h=%b d=%b q=%0d, expected v=1 h=%b d=%b q=%0d",
                     tag, res_valid, res_hit, res_drop, res_queue, e[5], e[4], e[3:0]);
        end
    endtask

    task automatic write_rule(input int idx, input logic [31:0] d);
        cfg_we = 1; cfg_idx = IW'(idx); cfg_data = d;
        @(negedge clk);
        cfg_we = 0;
        if (idx < NR) m_rule[idx] = d[30:0];
    endtask

    task automatic clear_rules();
        for (int i = 0; i < NR; i++) write_rule(i, 32'h0);
    endtask

    task automatic fill_frame(input logic [7:0] ds, input logic [15:0] port);
        for (int i = 0; i < 64; i++) fb[i] = 8'($urandom);
        fb[15] = ds; fb[36] = port[15:8]; fb[37] = port[7:0];
    endtask

    // Send fb[0:len-1]; check the verdict cycle and quiet cycles elsewhere.
    task automatic send_frame(input int len, input bit gaps, input string tag);
        int trig;
        logic [5:0] e;
        trig = (len < 38) ? len - 1 : 37;
        e = expect_verdict(len);
        for (int i = 0; i < len; i++) begin
            if (gaps && ($urandom % 4) == 0) begin
                rx_valid = 0; rx_sof = 0; rx_eof = 0;
                @(negedge clk);
                check_quiet({tag, " gap"});
            end
            rx_valid = 1; rx_sof = (i == 0); rx_eof = (i == len - 1); rx_byte = fb[i];
            @(negedge clk);
            if (i == trig) check_verdict(e, tag);
            else check_quiet({tag, " R8 non-trigger"});
        end
        rx_valid = 0; rx_sof = 0; rx_eof = 0;
        @(negedge clk);
        check_quiet({tag, " R8 after frame"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NR; i++) m_rule[i] = '0;
        rst_n = 0; cfg_we = 0; cfg_idx = '0; cfg_data = '0;
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_byte = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_quiet("R11 reset");

        // R11 / R6: cleared rules claim nothing.
        fill_frame(8'h2E, 16'h1234);
        send_frame(60, 0, "R11 R6 empty bank");

        // R8: stray bytes before any start marker are ignored.
        for (int i = 0; i < 40; i++) begin
            rx_valid = 1; rx_sof = 0; rx_eof = (i == 39); rx_byte = 8'(i);
            @(negedge clk);
            check_quiet("R8 stray bytes");
        end
        rx_valid = 0; rx_eof = 0;

        // R1 / R3: DS/TC-only rule.
        write_rule(0, mk_rule(0, 0, 1, 16'h0, 8'h2E, 4'd3));
        fill_frame(8'h2E, 16'h0001);
        send_frame(50, 0, "R3 ds match q3");
        fill_frame(8'h2F, 16'h0001);
        send_frame(50, 0, "R3 ds mismatch");
        // R1: bit 31 ignored.
        write_rule(0, mk_rule(0, 0, 1, 16'h0, 8'h2E, 4'd3) | 32'h8000_0000);
        fill_frame(8'h2E, 16'h0001);
        send_frame(45, 0, "R1 top bit ignored");

        // R2: port-only rule, big-endian.
        clear_rules();
        write_rule(1, mk_rule(0, 1, 0, 16'h1234, 8'h0, 4'd5));
        fill_frame(8'h00, 16'h1234);
        send_frame(64, 0, "R2 port match q5");
        fill_frame(8'h00, 16'h3412);
        send_frame(64, 0, "R2 byte order");

        // R4: both criteria enabled must both agree.
        clear_rules();
        write_rule(2, mk_rule(0, 1, 1, 16'hBEEF, 8'h10, 4'd9));
        fill_frame(8'h10, 16'hBEEE);
        send_frame(40, 0, "R4 one mismatch");
        fill_frame(8'h10, 16'hBEEF);
        send_frame(40, 0, "R4 both match q9");
        write_rule(3, mk_rule(0, 0, 0, 16'hBEEF, 8'h10, 4'd7));
        write_rule(2, 32'h0);
        send_frame(40, 0, "R4 no enables");

        // R5: lowest qualifying index wins.
        clear_rules();
        write_rule(4, mk_rule(0, 0, 1, 16'h0, 8'h44, 4'd12));
        write_rule(2, mk_rule(0, 1, 0, 16'h5555, 8'h0, 4'd6));
        fill_frame(8'h44, 16'h5555);
        send_frame(48, 0, "R5 priority q6");
        write_rule(1, mk_rule(0, 1, 1, 16'h5555, 8'h44, 4'd1));
        send_frame(48, 0, "R5 priority q1");

        // R7: drop on the winner.
        write_rule(0, mk_rule(1, 0, 1, 16'h0, 8'h44, 4'd8));
        send_frame(48, 0, "R7 drop");

        // R9: truncation.
        clear_rules();
        write_rule(0, mk_rule(0, 1, 0, 16'h0A0B, 8'h0, 4'd2));
        write_rule(1, mk_rule(0, 0, 1, 16'h0, 8'h33, 4'd4));
        fill_frame(8'h33, 16'h0A0B);
        send_frame(20, 0, "R9 short port q4");
        send_frame(10, 0, "R9 short ds");
        send_frame(37, 0, "R9 one short of port");
        send_frame(38, 0, "R9 exact length q2");
        send_frame(1, 0, "R8 single byte");

        // R10: out-of-range writes change nothing.
        clear_rules();
        write_rule(6, mk_rule(0, 0, 1, 16'h0, 8'h77, 4'd11));
        write_rule(7, mk_rule(0, 0, 1, 16'h0, 8'h77, 4'd13));
        fill_frame(8'h77, 16'h0);
        send_frame(40, 0, "R10 out of range");
        write_rule(5, mk_rule(0, 0, 1, 16'h0, 8'h77, 4'd15));
        send_frame(40, 0, "R10 in range q15");

        // Random mix.
        for (int n = 0; n < 400; n++) begin
            logic [7:0]  dsv [4];
            logic [15:0] pv  [4];
            int len;
            for (int k = 0; k < 4; k++) begin dsv[k] = 8'(k * 9 + 1); pv[k] = 16'(k * 257 + 3); end
            if (n % 20 == 0) begin
                for (int i = 0; i < NR; i++)
                    write_rule(i, mk_rule(1'($urandom % 5 == 0), 1'($urandom), 1'($urandom),
                                          pv[$urandom % 4], dsv[$urandom % 4], 4'($urandom)));
            end
            fill_frame(dsv[$urandom % 4], pv[$urandom % 4]);
            len = ($urandom % 3 == 0) ? 1 + int'($urandom % 64) : 38 + int'($urandom % 27);
            send_frame(len, 1'($urandom), "R4 R5 R9 random");
        end

        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule